// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Overflow Flag

This block divides a double-width dividend by a single-width divisor for a CPU datapath. It has two operand sizes. In the narrow size a 16-bit dividend is divided by an 8-bit divisor. In the wide size a 32-bit dividend is divided by a 16-bit divisor. Each size runs either unsigned or as two's complement. The quotient and the remainder come back packed into one result word, together with a flag. The flag reports a quotient that does not fit, or a zero divisor.

A caller presents the operands, sets the size and sign selects, and pulses `start`. A shift-subtract core then produces one quotient bit per clock. `busy` stays high while the core runs. `done` pulses for one cycle in the cycle the result and flag become valid. A zero divisor skips the iteration and finishes on the accepting edge. In that case the result is a fixed rearrangement of the dividend.

All widths scale from one parameter, `BASE_W` (default 8). The narrow divisor is `BASE_W` bits wide and the wide divisor is `2*BASE_W` bits wide.

Top module: `div_unit`

## Requirements
- R1: Narrow size (`word_mode`=0) unsigned: the divisor is `divisor[7:0]` and the dividend is `dividend[15:0]`. The result has the quotient in `result[7:0]`, the remainder in `result[15:8]` and zeros in `result[31:16]`.
- R2: Wide size (`word_mode`=1): the divisor is `divisor[15:0]` and the dividend is `dividend[31:0]`. The result has the quotient in `result[15:0]` and the remainder in `result[31:16]`.
- R3: A zero divisor (only `divisor[7:0]` counts in the narrow size) sets `ovf`. In the narrow size the result is {16'h0, dividend[7:0], ~dividend[15:8]}. In the wide size the result is {dividend[15:0], ~dividend[31:16]}. `done` rises on the accepting edge and `busy` stays low.
- R4: Unsigned mode (`signed_mode`=0) with a nonzero divisor sets `ovf` exactly when the quotient is above 0xFF (narrow) or 0xFFFF (wide). Only the low bits of the quotient are kept.
- R5: Signed mode (`signed_mode`=1) reads the operands as two's complement. The quotient truncates toward zero. The remainder has the sign of the dividend. Both are returned as two's-complement low bits.
- R6: In signed mode `ovf` is set only when the quotient is positive and above 0xFF (narrow) or 0xFFFF (wide). A negative quotient never sets it, however large its magnitude.
- R7: With a nonzero divisor, `done` rises on the 16th (narrow) or 32nd (wide) clock edge after the edge that accepts `start`. `busy` is high from the accepting edge until that edge.
- R8: `done` is high for one cycle and never while `busy`. A `start` while `busy` is ignored and does not change the running operation.
- R9: A synchronous active-high `rst` clears `busy`, `done`, `result` and `ovf`, and abandons any running operation.
- R10: `result` and `ovf` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; sampled only while idle |
| word_mode | input | 1 | 0 = narrow size, 1 = wide size |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| dividend | input | 4*BASE_W | Dividend; the narrow size uses the low 2*BASE_W bits |
| divisor | input | 2*BASE_W | Divisor; the narrow size uses the low BASE_W bits |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 4*BASE_W | Packed remainder (upper part) and quotient (lower part) |
| ovf | output | 1 | Quotient overflow or zero divisor |

## Verification
The bench builds the block with the default `BASE_W` of 8. This gives the 16/8 and 32/16 operand pairs. Every corner can then be reached exactly with 64-bit integer division in the reference: the most negative dividend over minus one, all-ones over one, and divisors whose upper narrow byte is set while the low byte is zero. The latency of 16 and 32 edges keeps several hundred mixed operations short. Starts issued while busy and a reset in the middle of an operation are also in reach.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {PH_IDLE, PH_RUN} div_phase_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int BASE_W = 8
) (
  input  logic                  word_mode,
  input  logic                  signed_mode,
  input  logic [4*BASE_W-1:0]   dividend,
  input  logic [2*BASE_W-1:0]   divisor,
  output logic [4*BASE_W-1:0]   dvd_mag,
  output logic [2*BASE_W-1:0]   dsr_mag,
  output logic                  dvd_neg,
  output logic                  dsr_neg,
  output logic                  dsr_zero,
  output logic [4*BASE_W-1:0]   zero_word
);
  localparam int HW = 2 * BASE_W;
  localparam int FW = 4 * BASE_W;

  function automatic logic [BASE_W-1:0] abs_b(input logic [BASE_W-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [HW-1:0] abs_h(input logic [HW-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [FW-1:0] abs_f(input logic [FW-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  always_comb begin
    if (word_mode) begin
      dvd_neg   = signed_mode & dividend[FW-1];
      dsr_neg   = signed_mode & divisor[HW-1];
      dvd_mag   = abs_f(dividend, dvd_neg);
      dsr_mag   = abs_h(divisor, dsr_neg);
      dsr_zero  = (divisor == '0);
      zero_word = {dividend[HW-1:0], ~dividend[FW-1:HW]};
    end else begin
      dvd_neg   = signed_mode & dividend[HW-1];
      dsr_neg   = signed_mode & divisor[BASE_W-1];
      dvd_mag   = {{HW{1'b0}}, abs_h(dividend[HW-1:0], dvd_neg)};
      dsr_mag   = {{BASE_W{1'b0}}, abs_b(divisor[BASE_W-1:0], dsr_neg)};
      dsr_zero  = (divisor[BASE_W-1:0] == '0);
      zero_word = {{HW{1'b0}}, dividend[BASE_W-1:0], ~dividend[HW-1:BASE_W]};
    end
  end
endmodule

// File: rtl/div_core.sv
module div_core
  import div_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  word_mode,
  input  logic [4*BASE_W-1:0]   dvd_mag,
  input  logic [2*BASE_W-1:0]   dsr_mag,
  output logic                  run,
  output logic                  last,
  output logic [4*BASE_W-1:0]   quo_nxt,
  output logic [2*BASE_W-1:0]   rem_nxt
);
  localparam int HW = 2 * BASE_W;
  localparam int FW = 4 * BASE_W;
  localparam int CW = $clog2(FW + 1);

  div_phase_e     phase;
  logic [FW-1:0]  acc_q;
  logic [HW-1:0]  acc_r;
  logic [HW-1:0]  dsr_r;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  limit_r;
  logic [HW:0]    trial;
  logic [HW:0]    diff;
  logic           fits;

  // one restoring step: bring in the next dividend bit, subtract if it fits
  always_comb begin
    trial   = {acc_r, acc_q[FW-1]};
    diff    = trial - {1'b0, dsr_r};
    fits    = (trial >= {1'b0, dsr_r});
    rem_nxt = fits ? diff[HW-1:0] : trial[HW-1:0];
    quo_nxt = {acc_q[FW-2:0], fits};
  end

  assign run  = (phase == PH_RUN);
  assign last = run && (cnt == limit_r - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      acc_q   <= '0;
      acc_r   <= '0;
      dsr_r   <= '0;
      cnt     <= '0;
      limit_r <= '0;
    end else if (phase == PH_IDLE) begin
      if (load) begin
        acc_q   <= word_mode ? dvd_mag : (dvd_mag << HW);
        acc_r   <= '0;
        dsr_r   <= dsr_mag;
        cnt     <= '0;
        limit_r <= word_mode ? CW'(FW) : CW'(HW);
        phase   <= PH_RUN;
      end
    end else begin
      acc_q <= quo_nxt;
      acc_r <= rem_nxt;
      cnt   <= cnt + CW'(1);
      if (last) phase <= PH_IDLE;
    end
  end

  AST_PARTIAL_REM: assert property (@(posedge clk) disable iff (rst)
    run |-> (acc_r < dsr_r)); // R1
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int BASE_W = 8
) (
  input  logic                  word_mode,
  input  logic                  quo_neg,
  input  logic                  rem_neg,
  input  logic [4*BASE_W-1:0]   quo_mag,
  input  logic [2*BASE_W-1:0]   rem_mag,
  output logic [4*BASE_W-1:0]   packed_word,
  output logic                  ovf
);
  localparam int HW = 2 * BASE_W;
  localparam int FW = 4 * BASE_W;

  function automatic logic [FW-1:0] sign_f(input logic [FW-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [HW-1:0] sign_h(input logic [HW-1:0] v, input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [FW-1:0] quo_limit(input logic wide);
    return wide ? {{HW{1'b0}}, {HW{1'b1}}} : {{(FW-BASE_W){1'b0}}, {BASE_W{1'b1}}};
  endfunction

  logic [FW-1:0] quo_s;
  logic [HW-1:0] rem_s;

  always_comb begin
    quo_s = sign_f(quo_mag, quo_neg);
    rem_s = sign_h(rem_mag, rem_neg);
    if (word_mode) packed_word = {rem_s, quo_s[HW-1:0]};
    else           packed_word = {{HW{1'b0}}, rem_s[BASE_W-1:0], quo_s[BASE_W-1:0]};
    ovf = !quo_neg && (quo_mag > quo_limit(word_mode));
  end
endmodule

// File: rtl/div_unit.sv
module div_unit #(
  parameter int BASE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  word_mode,
  input  logic                  signed_mode,
  input  logic [4*BASE_W-1:0]   dividend,
  input  logic [2*BASE_W-1:0]   divisor,
  output logic                  busy,
  output logic                  done,
  output logic [4*BASE_W-1:0]   result,
  output logic                  ovf
);
  localparam int HW = 2 * BASE_W;
  localparam int FW = 4 * BASE_W;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] dvd_mag, zero_word, quo_nxt, packed_word;
  logic [HW-1:0] dsr_mag, rem_nxt;
  logic          dvd_neg, dsr_neg, dsr_zero;
  logic          accept, load_core, step_last, core_run, fix_ovf;
  logic          word_l, sdiff_l, dneg_l;
  logic [CW-1:0] busy_cycles;

  div_operand_prep #(.BASE_W(BASE_W)) u_prep (
    .word_mode   (word_mode),
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .dvd_mag     (dvd_mag),
    .dsr_mag     (dsr_mag),
    .dvd_neg     (dvd_neg),
    .dsr_neg     (dsr_neg),
    .dsr_zero    (dsr_zero),
    .zero_word   (zero_word)
  );

  assign accept    = start && !core_run;
  assign load_core = accept && !dsr_zero;

  div_core #(.BASE_W(BASE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (load_core),
    .word_mode (word_mode),
    .dvd_mag   (dvd_mag),
    .dsr_mag   (dsr_mag),
    .run       (core_run),
    .last      (step_last),
    .quo_nxt   (quo_nxt),
    .rem_nxt   (rem_nxt)
  );

  div_result_fix #(.BASE_W(BASE_W)) u_fix (
    .word_mode   (word_l),
    .quo_neg     (sdiff_l),
    .rem_neg     (dneg_l),
    .quo_mag     (quo_nxt),
    .rem_mag     (rem_nxt),
    .packed_word (packed_word),
    .ovf         (fix_ovf)
  );

  assign busy = core_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_l  <= 1'b0;
      sdiff_l <= 1'b0;
      dneg_l  <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      ovf     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_core) begin
        word_l  <= word_mode;
        sdiff_l <= dvd_neg ^ dsr_neg;
        dneg_l  <= dvd_neg;
      end
      if (accept && dsr_zero) begin
        result <= zero_word;
        ovf    <= 1'b1;
        done   <= 1'b1;
      end else if (step_last) begin
        result <= packed_word;
        ovf    <= fix_ovf;
        done   <= 1'b1;
      end
    end
  end

  // independent count of busy cycles, used only to bound the iteration window
  always_ff @(posedge clk) begin
    if (rst || load_core) busy_cycles <= '0;
    else if (core_run)    busy_cycles <= busy_cycles + CW'(1);
  end

  AST_ZERO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && dsr_zero) |=> (done && ovf && !busy)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (step_last && sdiff_l) |=> !ovf); // R6
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cycles < (word_l ? CW'(FW) : CW'(HW)))); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !step_last) |=> busy); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!busy && !done && (result == '0) && !ovf)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(ovf))); // R10
endmodule

// File: tb/tb_div_unit.sv
module tb_div_unit;
  localparam int CYC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        word_mode = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, ovf;
  logic [31:0] result;

  int    compared = 0;
  int    mismatched = 0;
  string cur_req = "R9";

  always #(CYC/2) clk = ~clk;

  div_unit #(.BASE_W(8)) dut (
    .clk(clk), .rst(rst), .start(start), .word_mode(word_mode),
    .signed_mode(signed_mode), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result), .ovf(ovf)
  );

  // reference arithmetic on 64-bit integers
  function automatic void ref_div(input logic w, input logic s, input logic [31:0] a,
                                  input logic [15:0] d, output logic [31:0] res, output logic ov);
    longint x, y, q, r;
    if (!w) begin
      if (d[7:0] == 8'h0) begin res = {16'h0, a[7:0], ~a[15:8]}; ov = 1'b1; return; end
      x = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
      y = s ? longint'($signed(d[7:0]))  : longint'(d[7:0]);
      q = x / y; r = x % y;
      ov = (q > 255);
      res = {16'h0, r[7:0], q[7:0]};
    end else begin
      if (d == 16'h0) begin res = {a[15:0], ~a[31:16]}; ov = 1'b1; return; end
      x = s ? longint'($signed(a)) : longint'(a);
      y = s ? longint'($signed(d)) : longint'(d);
      q = x / y; r = x % y;
      ov = (q > 65535);
      res = {r[15:0], q[15:0]};
    end
  endfunction

  // cycle model
  logic        m_busy = 0, m_done = 0, m_ovf = 0, p_ovf = 0;
  logic [31:0] m_res = '0, p_res = '0;
  int          m_cnt = 0;

  always @(posedge clk) begin
    logic [31:0] r; logic o; logic z;
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = '0; m_ovf = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == 1) begin m_busy = 0; m_done = 1; m_res = p_res; m_ovf = p_ovf; end
        else m_cnt--;
      end else if (start) begin
        ref_div(word_mode, signed_mode, dividend, divisor, r, o);
        z = word_mode ? (divisor == 16'h0) : (divisor[7:0] == 8'h0);
        if (z) begin m_res = r; m_ovf = o; m_done = 1; end
        else begin m_busy = 1; m_cnt = word_mode ? 32 : 16; p_res = r; p_ovf = o; end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    compared++;
    if (busy !== m_busy || done !== m_done || result !== m_res || ovf !== m_ovf) begin
      mismatched++;
      $display("FAIL %s model: actual busy=%b done=%b res=%h ovf=%b expected busy=%b done=%b res=%h ovf=%b",
               cur_req, busy, done, result, ovf, m_busy, m_done, m_res, m_ovf);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic w, input logic s, input logic [31:0] a,
                        input logic [15:0] d, input logic [31:0] exp_res, input logic exp_ov);
    int n; int exp_n; logic z;
    z = w ? (d == 16'h0) : (d[7:0] == 8'h0);
    exp_n = z ? 1 : (w ? 33 : 17);
    @(negedge clk);
    cur_req = req; word_mode = w; signed_mode = s; dividend = a; divisor = d; start = 1'b1;
    @(posedge clk); #2; n = 1; start = 1'b0;
    while (!done && n < 40) begin @(posedge clk); #2; n++; end
    chk("R7", "edges to done", n, exp_n);
    chk(req, "result", result, exp_res);
    chk(req, "ovf", {31'h0, ovf}, {31'h0, exp_ov});
    @(posedge clk); #2;
    chk("R8", "done after pulse", {31'h0, done}, 32'h0);
  endtask

  initial begin
    #(CYC * 150000);
    mismatched++;
    $display("FAIL R7 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] er; logic eo; logic [31:0] held;
    repeat (3) @(posedge clk);
    #2;
    chk("R9", "reset busy/done/ovf", {29'h0, busy, done, ovf}, 32'h0);
    chk("R9", "reset result", result, 32'h0);
    @(negedge clk); rst = 1'b0;

    run_op("R1", 0, 0, 32'h0000_03E8, 16'h0007, 32'h0000_068E, 0);
    run_op("R4", 0, 0, 32'h0000_1234, 16'h0002, 32'h0000_001A, 1);
    run_op("R3", 0, 0, 32'h0000_ABCD, 16'h0000, 32'h0000_CD54, 1);
    run_op("R3", 0, 1, 32'h0000_ABCD, 16'h0100, 32'h0000_CD54, 1);
    run_op("R2", 1, 0, 32'h0001_86A0, 16'd300, 32'h0064_014D, 0);
    run_op("R4", 1, 0, 32'hFFFF_FFFF, 16'h0001, 32'h0000_FFFF, 1);
    run_op("R3", 1, 0, 32'h1234_5678, 16'h0000, 32'h5678_EDCB, 1);
    run_op("R5", 0, 1, 32'h0000_FF9C, 16'h0007, 32'h0000_FEF2, 0);
    run_op("R5", 0, 1, 32'h0000_0064, 16'h00F9, 32'h0000_02F2, 0);
    run_op("R5", 1, 1, 32'hFFFF_FFF9, 16'h0002, 32'hFFFF_FFFD, 0);
    run_op("R6", 0, 1, 32'h0000_8000, 16'h00FF, 32'h0000_0000, 1);
    run_op("R6", 0, 1, 32'h0000_8000, 16'h0001, 32'h0000_0000, 0);
    run_op("R6", 0, 1, 32'h0000_03E8, 16'h00FD, 32'h0000_01B3, 0);
    run_op("R6", 0, 1, 32'h0000_03E8, 16'h0003, 32'h0000_014D, 1);
    run_op("R6", 1, 1, 32'hFFF0_BDC0, 16'h0003, 32'hFFFF_E9EB, 0);
    run_op("R6", 1, 1, 32'h8000_0000, 16'hFFFF, 32'h0000_0000, 1);

    // R10: values hold while idle
    held = result;
    repeat (6) @(posedge clk);
    #2;
    chk("R10", "held result", result, held);

    // R8: a start while busy is ignored
    @(negedge clk);
    cur_req = "R8"; word_mode = 0; signed_mode = 0; dividend = 32'h03E8; divisor = 16'h0007; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    word_mode = 1; dividend = 32'h1234_5678; divisor = 16'h0000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(posedge clk);
    #2;
    chk("R8", "result after ignored start", result, 32'h0000_068E);
    chk("R8", "busy after ignored start", {31'h0, busy}, 32'h0);

    // R9: reset in the middle of an operation
    @(negedge clk);
    cur_req = "R9"; word_mode = 1; signed_mode = 0; dividend = 32'h0001_86A0; divisor = 16'd300; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R9", "mid-op reset flags", {29'h0, busy, done, ovf}, 32'h0);
    chk("R9", "mid-op reset result", result, 32'h0);
    @(negedge clk); rst = 1'b0;
    repeat (40) @(posedge clk);
    #2;
    chk("R9", "abandoned op stays idle", {30'h0, busy, done}, 32'h0);

    // mixed random operations
    for (int i = 0; i < 300; i++) begin
      logic w, s; logic [31:0] a; logic [15:0] d;
      w = 1'($urandom); s = 1'($urandom); a = $urandom;
      d = ($urandom % 8 == 0) ? {8'($urandom), 8'h00} : 16'($urandom);
      if ($urandom % 4 == 0) d = w ? 16'h0001 : 16'h00FF;
      ref_div(w, s, a, d, er, eo);
      run_op(w ? (s ? "R6" : "R2") : (s ? "R5" : "R1"), w, s, a, d, er, eo);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule